// File: doc/BRIEF.md
# Two-Digit Decimal Counter

This block counts from 00 to 99 in binary-coded decimal and then starts again at 00. It keeps two 4-bit decimal digits. The units digit steps by one on every clock edge at which the count enable is high. The tens digit steps only when the units digit rolls from 9 back to 0. The tens digit follows the same rule, so the full sequence has one hundred states.

A carry output goes high while the count is 99 and the enable is high. It is combinational, so it marks the same clock edge on which the counter returns to 00. A second stage can take this output as its enable, and further stages can be chained the same way. A synchronous clear returns both digits to zero and takes priority over the enable. An active-low synchronous reset does the same.

Top module: `bcd_two_digit_counter`

## Requirements
- R1: On an edge where the units digit is told to step and clear is low, its value goes up by one. When it is at 9, it goes to 0 instead.
- R2: `ones_q` carries the units digit and `tens_q` carries the tens digit. Read as {tens_q, ones_q}, they form the packed BCD value, for example 8'h45 for forty-five.
- R3: The tens digit changes only on an edge where enable is high and the units digit is 9. It holds on every other edge.
- R4: From 99 with enable high and clear low, the next edge gives 00, so a full cycle is 100 enabled edges.
- R5: With enable low and clear low, both digits keep their values across the edge.
- R6: `carry_out` is 1 exactly when `en` is 1 and the count is 99. It is 0 otherwise and follows the inputs within the same cycle.
- R7: With `clr` high, the next edge gives 00 whatever the value of `en`.
- R8: Neither digit output ever shows a code from 10 to 15.
- R9: With `rst_n` low at a rising edge, both digits are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear to 00; overrides en |
| en | input | 1 | Count enable |
| ones_q | output | 4 | Units digit, BCD |
| tens_q | output | 4 | Tens digit, BCD |
| carry_out | output | 1 | High while count is 99 and en is high |

## Verification
The digit outputs are registered and change one clock edge after the inputs that cause the change. The bench therefore sets `clr`, `en` and `rst_n` at a falling edge and reads the digits at the next falling edge, after exactly one rising edge. `carry_out` has no register on its path, so the bench reads it in the same half cycle that the enable is applied, before the rising edge. Each step keeps to this order: drive, check the carry, one rising edge, check the digits.

// File: rtl/bcd_cnt_pkg.sv
// Package: shared constants and the digit type for the decimal counter.
// Assumes 4-bit BCD digits that count up to 9.
package bcd_cnt_pkg;
    localparam int DIGIT_W   = 4;
    localparam int DIGIT_MAX = 9;
    typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/bcd_digit_cell.sv
// One BCD digit: steps by one when inc is high and wraps 9 -> 0.
// It raises wrap in the same cycle when it is about to roll over.
// Assumes clr and rst_n are synchronous; clear wins over inc.
module bcd_digit_cell
    import bcd_cnt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  logic   inc,
    output digit_t val_q,
    output logic   wrap
);
    logic at_max;

    // Purpose: detect the top code and the rollover request.
    always_comb begin
        at_max = (val_q == digit_t'(DIGIT_MAX));
        wrap   = inc && at_max;
    end

    // Purpose: hold, step or wrap the digit register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            val_q <= '0;
        end else if (inc) begin
            val_q <= at_max ? '0 : val_q + digit_t'(1);
        end
    end

    AST_DIGIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        val_q <= digit_t'(DIGIT_MAX)); // R8
    AST_HOLD_WITHOUT_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(val_q)); // R5
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && val_q == digit_t'(DIGIT_MAX)) |=> (val_q == '0)); // R1
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && val_q < digit_t'(DIGIT_MAX)) |=> (val_q == digit_t'($past(val_q) + digit_t'(1)))); // R1
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (val_q == '0)); // R7
endmodule

// File: rtl/bcd_term_detect.sv
// Terminal-count detector: high when every digit is 9 and the enable is high.
// It is purely combinational, so a downstream stage sees it in the same cycle.
module bcd_term_detect
    import bcd_cnt_pkg::*;
#(
    parameter int NUM_DIGITS = 2
) (
    input  digit_t digits [NUM_DIGITS],
    input  logic   en,
    output logic   term
);
    // Purpose: AND together the per-digit top-code matches with the enable.
    always_comb begin
        term = en;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            term = term && (digits[i] == digit_t'(DIGIT_MAX));
        end
    end
endmodule

// File: rtl/bcd_two_digit_counter.sv
// Two-digit BCD up-counter. The units cell is enabled by en. Each higher
// cell is enabled by the wrap output of the cell below it. carry_out marks
// the 99 -> 00 edge so that stages can be chained.
// Assumes a single clock; rst_n, clr and en are synchronous to clk.
module bcd_two_digit_counter
    import bcd_cnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    output logic [3:0] ones_q,
    output logic [3:0] tens_q,
    output logic       carry_out
);
    localparam int NUM_DIGITS = 2;

    digit_t               digit_q [NUM_DIGITS];
    logic [NUM_DIGITS:0]  ripple;
    logic                 term_all_max;

    assign ripple[0] = en;

    generate
        for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
            bcd_digit_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr),
                .inc   (ripple[g]),
                .val_q (digit_q[g]),
                .wrap  (ripple[g+1])
            );
        end
    endgenerate

    bcd_term_detect #(.NUM_DIGITS(NUM_DIGITS)) u_term (
        .digits (digit_q),
        .en     (en),
        .term   (term_all_max)
    );

    // Purpose: map the digit cells onto the output ports.
    always_comb begin
        ones_q    = digit_q[0];
        tens_q    = digit_q[1];
        carry_out = term_all_max;
    end

    AST_CHAIN_MATCHES_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        ripple[NUM_DIGITS] == term_all_max); // R6
    AST_CARRY_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (en && ones_q == 4'd9 && tens_q == 4'd9)); // R6
    AST_TENS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(en && ones_q == 4'd9)) |=> $stable(tens_q)); // R3
    AST_FULL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && en && ones_q == 4'd9 && tens_q == 4'd9) |=> (ones_q == 4'd0 && tens_q == 4'd0)); // R4
endmodule

// File: tb/bcd_two_digit_counter_bench.sv
module bcd_two_digit_counter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       en = 1'b0;
    logic [3:0] ones_q;
    logic [3:0] tens_q;
    logic       carry_out;

    int n_tests = 0;
    int n_fail  = 0;
    int model   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    bcd_two_digit_counter u_bcd_two_digit_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .en        (en),
        .ones_q    (ones_q),
        .tens_q    (tens_q),
        .carry_out (carry_out)
    );

    // Vector: [9] clr, [8] en, [7:0] expected {tens, ones} after the edge.
    localparam logic [9:0] VEC [0:7] = '{
        10'b01_0000_0001, 10'b00_0000_0001, 10'b01_0000_0010, 10'b11_0000_0000,
        10'b01_0000_0001, 10'b10_0000_0000, 10'b01_0000_0001, 10'b01_0000_0010
    };

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Drive at a falling edge, check the carry, take one rising edge, return at the falling edge.
    task automatic step(input logic c, input logic e, input string req_carry);
        clr = c;
        en  = e;
        #1;
        chk(req_carry, int'(carry_out), int'(e && model == 99));
        @(posedge clk);
        @(negedge clk);
        if (c) model = 0;
        else if (e) model = (model + 1) % 100;
    endtask

    task automatic chk_count(input string req);
        chk(req, int'(ones_q), model % 10);
        chk(req, int'(tens_q), model / 10);
    endtask

    initial begin
        #(4 * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R9 reset ones", int'(ones_q), 0);
        chk("R9 reset tens", int'(tens_q), 0);
        rst_n = 1'b1;
        model = 0;

        // Table walk: enable, hold, clear priority.
        for (int i = 0; i < 8; i++) begin
            step(VEC[i][9], VEC[i][8], "R6 carry in table");
            chk("R1/R5/R7 table vector", int'({tens_q, ones_q}), int'(VEC[i][7:0]));
        end

        // Full sweep: 100 enabled edges from 00 give the whole cycle.
        step(1'b1, 1'b0, "R6 carry during clear");
        for (int i = 0; i < 100; i++) begin
            int prev;
            prev = model;
            step(1'b0, 1'b1, "R6 carry during sweep");
            chk_count("R1 R3 R4 sweep count");
            chk("R8 ones in range", int'(ones_q <= 4'd9), 1);
            chk("R8 tens in range", int'(tens_q <= 4'd9), 1);
            if (prev == 9) chk("R3 tens steps on units wrap", int'(tens_q), 1);
            if (prev == 99) chk("R4 wrap to 00", int'({tens_q, ones_q}), 0);
            if (prev == 44) chk("R2 packed BCD 45", int'({tens_q, ones_q}), 8'h45);
        end

        // Climb to 99, then check that enable low holds with the carry low.
        for (int i = 0; i < 99; i++) step(1'b0, 1'b1, "R6 carry climb");
        chk_count("R1 reached 99");
        step(1'b0, 1'b0, "R6 carry low with en low at 99");
        chk_count("R5 hold at 99");
        en = 1'b1;
        #1;
        chk("R6 carry at 99 with en", int'(carry_out), 1);
        step(1'b1, 1'b1, "R6 carry at 99 with clr");
        chk_count("R7 clear beats enable");

        // Hold at a mid value with the tens digit stable.
        for (int i = 0; i < 19; i++) step(1'b0, 1'b1, "R6 carry climb mid");
        step(1'b0, 1'b0, "R6 carry mid hold");
        chk_count("R5 hold at 19");
        step(1'b0, 1'b1, "R6 carry mid");
        chk("R3 tens steps 19->20", int'(tens_q), 2);

        // Reset in the middle of the count.
        rst_n = 1'b0;
        step(1'b0, 1'b1, "R6 carry before reset");
        model = 0;
        chk_count("R9 mid-count reset");
        rst_n = 1'b1;
        step(1'b0, 1'b1, "R6 carry after reset");
        chk_count("R1 count after reset");

        done = 1'b1;
        report();
    end
endmodule